// File: doc/BRIEF.md
# Parallel flash command interpreter

This block is a clocked model of the command logic of an 8-bit parallel flash device. A host drives an address, a write byte and a single-cycle write strobe. The block tracks key sequences on that bus and turns them into operations on a parameterised byte array. The operations are byte program, whole-array erase, sector erase, boot-sector lockout, and entry to or exit from an identification read mode. Reads take one cycle. They return either array contents or identification bytes.

The array is split into a boot sector, two small parameter sectors and two large main sectors. Every sector boundary and the array size are parameters, so a bench can run a scaled copy of the full map. The block only ever lowers bits when it programs. Erase restores bytes to FFh one byte per clock, and `busy` stays high while an operation is pending.

Top module: `flash_cmd_top`

## Requirements
- R1: A command opens with two key writes, AAh to command address 5555h and then 55h to 2AAAh. A third write to 5555h selects the command: A0h program, 80h erase/lock family, 90h identification entry. Any write that does not match the expected step returns the interpreter to idle and leaves the array unchanged.
- R2: After selector A0h, the next write programs its address. The new byte is the old byte ANDed with the write data, and the result is readable once `busy` falls.
- R3: After selector 80h, a second key pair (AAh at 5555h, 55h at 2AAAh) and then 10h at 5555h erase the whole array to FFh while the lock is clear. `busy` stays high for exactly one cycle per byte erased.
- R4: The same whole-array erase leaves the boot sector untouched while the lock is set.
- R5: After 80h and the second key pair, 30h written to any address erases the sector that contains that address. A parameter sector erase clears only that sector.
- R6: A sector erase aimed at main sector 1 also clears both parameter sectors. A sector erase aimed at main sector 2 clears only main sector 2.
- R7: A sector erase aimed at the boot sector does nothing and leaves `busy` low.
- R8: After 80h and the second key pair, 40h at 5555h sets the boot lock, and only reset clears it. While the lock is set, a program aimed at the boot sector is dropped.
- R9: In identification mode, a read at array offset 0 returns 1Fh, offset 1 returns 07h, offset 2 returns the lock in bit 0 (1 = locked), and any other offset returns 00h.
- R10: Identification mode ends on a single F0h write to any address while idle, or on the key pair followed by F0h at 5555h. Array reads then resume.
- R11: Command addresses are compared on bus address bits 14..0 only. Higher bits do not affect decoding.
- R12: `busy` is high from the cycle after a program or erase is accepted until it completes. A program keeps it high for PROG_LAT cycles. Writes seen while `busy` is high are ignored.
- R13: After reset, `busy` is low, `rdData` is 00h, the lock is clear and the block is in array read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| addr | input | BUS_AW | host address; low ARR_AW bits index the array |
| wdata | input | 8 | write byte |
| wrEn | input | 1 | one-cycle write strobe |
| rdEn | input | 1 | read request, data on rdData next cycle |
| rdData | output | 8 | read result |
| busy | output | 1 | program or erase in progress |

## Verification
The assertions assume the host never holds `wrEn` or `rdEn` through reset in a way that matters. They also assume a read issued in the same cycle as an identification-mode change is served under the mode that was in force before that edge. The stimulus pulses each write for exactly one cycle with an idle cycle after it. It waits for `busy` to fall before it checks results, and it avoids the key byte AAh in its random noise writes so that noise cannot open a sequence by accident. The only writes issued during `busy` are the deliberate ones that check they are ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [14:0] ADR_KEY1   = 15'h5555;
  localparam logic [14:0] ADR_KEY2   = 15'h2AAA;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  OP_PROG    = 8'hA0;
  localparam logic [7:0]  OP_ERASE   = 8'h80;
  localparam logic [7:0]  OP_IDIN    = 8'h90;
  localparam logic [7:0]  OP_QUIT    = 8'hF0;
  localparam logic [7:0]  OP_CHIP    = 8'h10;
  localparam logic [7:0]  OP_SECT    = 8'h30;
  localparam logic [7:0]  OP_LOCK    = 8'h40;
  localparam logic [7:0]  ID_MAKER   = 8'h1F;
  localparam logic [7:0]  ID_DEVICE  = 8'h07;
  localparam logic [7:0]  FILL_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_KEY1, S_KEY2, S_PROG, S_ERA3, S_ERA4, S_ERA5
  } seqState_t;

  typedef struct packed {
    logic prog;
    logic chipErase;
    logic sectErase;
    logic lockSet;
    logic idEnter;
    logic idExit;
  } cmdStrobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [14:0] cmdAddr,
  input  logic [7:0]  wdata,
  input  logic        busy,
  output cmdStrobe_t  strb
);
  seqState_t st, nxt;
  logic atK1, atK2;

  assign atK1 = (cmdAddr == ADR_KEY1);
  assign atK2 = (cmdAddr == ADR_KEY2);

  always_comb begin
    nxt  = st;
    strb = '0;
    if (wrEn && !busy) begin
      nxt = S_IDLE;
      case (st)
        S_IDLE: begin
          if (wdata == OP_QUIT) strb.idExit = 1'b1;
          else if (atK1 && wdata == KEY_FIRST) nxt = S_KEY1;
        end
        S_KEY1: if (atK2 && wdata == KEY_SECOND) nxt = S_KEY2;
        S_KEY2: begin
          if (atK1) begin
            case (wdata)
              OP_PROG:  nxt = S_PROG;
              OP_ERASE: nxt = S_ERA3;
              OP_IDIN:  strb.idEnter = 1'b1;
              OP_QUIT:  strb.idExit = 1'b1;
              default:  nxt = S_IDLE;
            endcase
          end
        end
        S_PROG: strb.prog = 1'b1;
        S_ERA3: if (atK1 && wdata == KEY_FIRST) nxt = S_ERA4;
        S_ERA4: if (atK2 && wdata == KEY_SECOND) nxt = S_ERA5;
        S_ERA5: begin
          if (wdata == OP_SECT) strb.sectErase = 1'b1;
          else if (atK1 && wdata == OP_CHIP) strb.chipErase = 1'b1;
          else if (atK1 && wdata == OP_LOCK) strb.lockSet = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end
endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array
  import flash_cmd_pkg::*;
#(
  parameter int ARR_AW    = 10,
  parameter int BOOT_END  = 64,
  parameter int PAR1_END  = 96,
  parameter int PAR2_END  = 128,
  parameter int MAIN1_END = 512,
  parameter int PROG_LAT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  cmdStrobe_t        strb,
  input  logic [ARR_AW-1:0] arrOff,
  input  logic [7:0]        wdata,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              lockQ,
  output logic              idQ
);
  localparam int DEPTH = 1 << ARR_AW;
  localparam int CNT_W = $clog2(PROG_LAT + 1);
  localparam logic [ARR_AW-1:0] LAST_OFF = ARR_AW'(DEPTH - 1);

  logic [7:0]        mem [DEPTH];
  logic              erasing, progPend;
  logic [CNT_W-1:0]  progCnt;
  logic [ARR_AW-1:0] eraCur, eraLast, progOff;
  logic [7:0]        progData;
  logic              inBoot, secOk;
  logic [ARR_AW-1:0] secLo, secHi;

  // Sector decode: an erase range is always a contiguous span of offsets.
  always_comb begin
    inBoot = int'(arrOff) < BOOT_END;
    secOk  = 1'b1;
    secLo  = '0;
    secHi  = LAST_OFF;
    if (inBoot) begin
      secOk = 1'b0;
    end else if (int'(arrOff) < PAR1_END) begin
      secLo = ARR_AW'(BOOT_END);
      secHi = ARR_AW'(PAR1_END - 1);
    end else if (int'(arrOff) < PAR2_END) begin
      secLo = ARR_AW'(PAR1_END);
      secHi = ARR_AW'(PAR2_END - 1);
    end else if (int'(arrOff) < MAIN1_END) begin
      secLo = ARR_AW'(BOOT_END);          // main 1 takes both parameter sectors along
      secHi = ARR_AW'(MAIN1_END - 1);
    end else begin
      secLo = ARR_AW'(MAIN1_END);
      secHi = LAST_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      erasing  <= 1'b0;
      progPend <= 1'b0;
      progCnt  <= '0;
      eraCur   <= '0;
      eraLast  <= '0;
      progOff  <= '0;
      progData <= '0;
      lockQ    <= 1'b0;
      idQ      <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strb.lockSet) lockQ <= 1'b1;
      if (strb.idEnter)     idQ <= 1'b1;
      else if (strb.idExit) idQ <= 1'b0;

      if (erasing) begin
        if (eraCur == eraLast) erasing <= 1'b0;
        else                   eraCur  <= eraCur + 1'b1;
      end else if (strb.chipErase) begin
        erasing <= 1'b1;
        eraCur  <= lockQ ? ARR_AW'(BOOT_END) : '0;
        eraLast <= LAST_OFF;
      end else if (strb.sectErase && secOk) begin
        erasing <= 1'b1;
        eraCur  <= secLo;
        eraLast <= secHi;
      end

      if (progPend) begin
        if (progCnt == '0) progPend <= 1'b0;
        else               progCnt  <= progCnt - 1'b1;
      end else if (strb.prog && !(lockQ && inBoot)) begin
        progPend <= 1'b1;
        progCnt  <= CNT_W'(PROG_LAT - 1);
        progOff  <= arrOff;
        progData <= wdata;
      end

      if (rdEn) begin
        if (idQ) begin
          if (arrOff == ARR_AW'(0))      rdData <= ID_MAKER;
          else if (arrOff == ARR_AW'(1)) rdData <= ID_DEVICE;
          else if (arrOff == ARR_AW'(2)) rdData <= {7'b0, lockQ};
          else                           rdData <= 8'h00;
        end else begin
          rdData <= mem[arrOff];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (erasing)                       mem[eraCur]  <= FILL_BYTE;
    else if (progPend && progCnt == '0) mem[progOff] <= mem[progOff] & progData;
  end

  assign busy = erasing | progPend;
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int BUS_AW    = 18,
  parameter int ARR_AW    = 10,
  parameter int BOOT_END  = 64,
  parameter int PAR1_END  = 96,
  parameter int PAR2_END  = 128,
  parameter int MAIN1_END = 512,
  parameter int PROG_LAT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              busy
);
  cmdStrobe_t strb;
  logic       lockQ, idQ;

  flash_cmd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .cmdAddr(addr[14:0]),
    .wdata(wdata), .busy(busy), .strb(strb)
  );

  flash_cmd_array #(
    .ARR_AW(ARR_AW), .BOOT_END(BOOT_END), .PAR1_END(PAR1_END),
    .PAR2_END(PAR2_END), .MAIN1_END(MAIN1_END), .PROG_LAT(PROG_LAT)
  ) u_arr (
    .clk(clk), .rst(rst), .strb(strb), .arrOff(addr[ARR_AW-1:0]),
    .wdata(wdata), .rdEn(rdEn), .rdData(rdData), .busy(busy),
    .lockQ(lockQ), .idQ(idQ)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int ARR_AW = 10
) (
  input logic              clk,
  input logic              rst,
  input cmdStrobe_t        strb,
  input logic              busy,
  input logic              lockQ,
  input logic              idQ,
  input logic              rdEn,
  input logic [ARR_AW-1:0] arrOff,
  input logic [7:0]        rdData
);
  a_r1_one_op: assert property (@(posedge clk) disable iff (rst) $onehot0(strb));
  a_r2_prog_busy: assert property (@(posedge clk) disable iff (rst)
    (strb.prog && !lockQ) |=> busy);
  a_r3_chip_busy: assert property (@(posedge clk) disable iff (rst) strb.chipErase |=> busy);
  a_r8_lock_sets: assert property (@(posedge clk) disable iff (rst) strb.lockSet |=> lockQ);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst) lockQ |=> lockQ);
  a_r9_maker: assert property (@(posedge clk) disable iff (rst)
    (idQ && rdEn && arrOff == ARR_AW'(0)) |=> rdData == ID_MAKER);
  a_r9_device: assert property (@(posedge clk) disable iff (rst)
    (idQ && rdEn && arrOff == ARR_AW'(1)) |=> rdData == ID_DEVICE);
  a_r12_quiet_busy: assert property (@(posedge clk) disable iff (rst) busy |-> strb == '0);
endmodule

bind flash_cmd_top flash_cmd_chk #(.ARR_AW(ARR_AW)) u_chk (
  .clk(clk), .rst(rst), .strb(strb), .busy(busy), .lockQ(lockQ), .idQ(idQ),
  .rdEn(rdEn), .arrOff(addr[ARR_AW-1:0]), .rdData(rdData)
);

// File: tb/flash_cmd_top_tb.sv
module flash_cmd_top_tb;
  localparam int BUS_AW = 18, ARR_AW = 10, DEPTH = 1 << ARR_AW;
  localparam int BOOT_END = 64, PAR1_END = 96, PAR2_END = 128, MAIN1_END = 512;
  localparam int PROG_LAT = 4;

  logic clk = 0, rst = 1, wrEn = 0, rdEn = 0, busy;
  logic [BUS_AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdData;
  logic [7:0] refMem [DEPTH];
  bit refLock = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_top #(.BUS_AW(BUS_AW), .ARR_AW(ARR_AW), .BOOT_END(BOOT_END),
    .PAR1_END(PAR1_END), .PAR2_END(PAR2_END), .MAIN1_END(MAIN1_END),
    .PROG_LAT(PROG_LAT)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .busy(busy));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(int a, int d);
    @(negedge clk); addr = BUS_AW'(a); wdata = 8'(d); wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic readByte(int a, output logic [7:0] v);
    @(negedge clk); addr = BUS_AW'(a); rdEn = 1;
    @(posedge clk); #1 v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic keys(int hi);
    busWrite(hi | 'h5555, 'hAA);
    busWrite(hi | 'h2AAA, 'h55);
  endtask

  function automatic void refFill(int lo, int hi);
    for (int i = lo; i <= hi; i++) refMem[i] = 8'hFF;
  endfunction

  function automatic void refSector(int off);
    if (off < BOOT_END) return;
    else if (off < PAR1_END) refFill(BOOT_END, PAR1_END - 1);
    else if (off < PAR2_END) refFill(PAR1_END, PAR2_END - 1);
    else if (off < MAIN1_END) refFill(BOOT_END, MAIN1_END - 1);
    else refFill(MAIN1_END, DEPTH - 1);
  endfunction

  task automatic doProg(int a, int d, int hi = 0);
    int n;
    keys(hi); busWrite(hi | 'h5555, 'hA0); busWrite(a, d);
    if (!(refLock && (a % DEPTH) < BOOT_END)) refMem[a % DEPTH] &= 8'(d);
    waitIdle(n);
  endtask

  task automatic eraseSeq(int a, int d);
    keys(0); busWrite('h5555, 'h80); keys(0); busWrite(a, d);
  endtask

  task automatic scan(string req);
    logic [7:0] v;
    int first = -1;
    logic [7:0] fa = 0, fe = 0;
    for (int i = 0; i < DEPTH; i++) begin
      readByte(i, v);
      if (v !== refMem[i] && first < 0) begin first = i; fa = v; fe = refMem[i]; end
    end
    total++;
    if (first >= 0) begin
      bad++;
      $display("FAIL %s at offset %0h actual=%0h expected=%0h", req, first, fa, fe);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R13 busy after reset", busy, 0);
    check("R13 rdData after reset", rdData, 0);
    rst = 0;

    // R3 whole erase while unlocked, busy one cycle per byte
    eraseSeq('h5555, 'h10);
    check("R12 busy after erase accept", busy, 1);
    waitIdle(n);
    check("R3 erase busy cycles", n, DEPTH);
    refFill(0, DEPTH - 1);
    scan("R3 array all FF");

    // R2 AND semantics and busy length
    keys(0); busWrite('h5555, 'hA0); busWrite('h100, 'h5A);
    waitIdle(n);
    check("R12 program busy cycles", n, PROG_LAT);
    refMem['h100] = 8'h5A;
    doProg('h100, 'h0F);
    readByte('h100, v); check("R2 program ANDs", v, 'h0A);

    // R11 high address bits ignored in decode
    doProg('h200, 'h33, 'h38000);
    readByte('h200, v); check("R11 aliased command", v, 'h33);

    // R1 broken sequence changes nothing
    busWrite('h5555, 'hAA); busWrite('h2AAA, 'h77);
    busWrite('h5555, 'hA0); busWrite('h300, 'h00);
    check("R1 no busy after broken seq", busy, 0);
    readByte('h300, v); check("R1 broken seq leaves byte", v, 'hFF);

    // random programs mixed with noise writes
    for (int k = 0; k < 40; k++) begin
      int a = int'($urandom_range(DEPTH - 1));
      int d = int'($urandom_range(255));
      int na = int'($urandom_range(32'h3FFFF));
      int nd = int'($urandom_range(255));
      if (nd == 'hAA) nd = 'h12;
      busWrite(na, nd);
      doProg(a, d);
    end
    scan("R2 random programs");

    // R5 / R7 / R6 sector erase
    doProg(10, 0); doProg(70, 0); doProg(100, 0); doProg(200, 0); doProg(600, 0);
    eraseSeq(70, 'h30); waitIdle(n); refSector(70);
    scan("R5 parameter sector erase");
    eraseSeq(5, 'h30);
    check("R7 boot sector erase not busy", busy, 0);
    readByte(10, v); check("R7 boot byte kept", v, 0);
    doProg(70, 0);
    eraseSeq(300, 'h30); waitIdle(n); refSector(300);
    scan("R6 main 1 erase takes parameters");
    doProg(100, 0);
    eraseSeq(800, 'h30); waitIdle(n); refSector(800);
    scan("R6 main 2 erase alone");

    // R9 / R10 identification
    keys(0); busWrite('h5555, 'h90);
    readByte(0, v); check("R9 maker code", v, 'h1F);
    readByte(1, v); check("R9 device code", v, 'h07);
    readByte(2, v); check("R9 lock bit clear", v, 0);
    readByte(3, v); check("R9 other offset", v, 0);
    busWrite('h1234, 'hF0);
    readByte(100, v); check("R10 single exit", v, refMem[100]);
    keys(0); busWrite('h5555, 'h90);
    keys(0); busWrite('h5555, 'hF0);
    readByte(100, v); check("R10 keyed exit", v, refMem[100]);

    // R8 lock, boot program dropped, readable
    eraseSeq('h5555, 'h40); refLock = 1;
    keys(0); busWrite('h5555, 'hA0); busWrite(20, 0);
    check("R8 boot program not busy", busy, 0);
    readByte(20, v); check("R8 boot program dropped", v, refMem[20]);
    keys(0); busWrite('h5555, 'h90);
    readByte(2, v); check("R8 lock bit set", v, 1);
    busWrite(0, 'hF0);

    // R4 locked whole erase and R12 writes ignored while busy
    eraseSeq('h5555, 'h10);
    keys(0); busWrite('h5555, 'hA0); busWrite('h300, 'h00);
    waitIdle(n);
    check("R4 locked erase busy cycles", n, DEPTH - BOOT_END - 8);
    refFill(BOOT_END, DEPTH - 1);
    scan("R4 boot kept through erase");
    readByte('h300, v); check("R12 program during busy ignored", v, 'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule